// File: doc/BRIEF.md
# Redundant Parameter Page Validator

This block checks a flash device's parameter page, which the device stores several times in a row. A byte stream carrying up to three 256-byte copies enters the block, one byte per valid cycle. Each copy is written to internal storage while a CRC-16 runs over it. The first copy whose checksum matches its own stored checksum is accepted. Any bytes after that point are dropped.

If all three copies fail, the block does not give up at once. It rebuilds a fourth page, bit by bit, from the three stored copies: each bit takes the value that most copies agree on. It then runs the CRC over the rebuilt page. The result is reported as a one-cycle done pulse together with level flags: accepted, accepted after voting, or failed. After the result, the chosen page can be read one byte at a time through a combinational read port. The controller that fetches the bytes from the device sits outside this block, as does any decoding of the page's fields.

Top module: `ppv_top`

## Requirements
- R1: The checksum is CRC-16 with polynomial 0x8005, MSB-first, with each byte XORed into bits 15:8 of the register. The register is preset to 0x4F4E for every copy and covers page bytes 0 to 253. A copy matches when byte 254 equals the CRC's low byte and byte 255 equals its high byte.
- R2: When a streamed copy matches, `done` pulses for exactly one cycle, in the cycle after the copy's byte 255 is accepted. In that cycle `page_ok`=1, `page_voted`=0 and `page_fail`=0.
- R3: Copy k occupies stream bytes 256k to 256k+255, and copies are tried in order 0, 1, 2. The copy index only moves forward, and a mismatching copy makes the block examine the next one.
- R4: Input bytes are ignored before the first `start` and after a result has been reported. They change neither the flags nor the page that is read back, and they produce no further `done`.
- R5: If all three copies mismatch, the rebuilt page has each bit set when at least two of the three copies (more than half) have that bit set.
- R6: The rebuilt page is checked with the same CRC as in R1. On a match the result is `page_ok`=1 with `page_voted`=1. On a mismatch it is `page_fail`=1 with `page_ok`=0. `page_ok` and `page_fail` are never both set.
- R7: After `done`, `rd_data` combinationally returns byte `rd_addr` of the chosen page: the first matching copy, or the rebuilt page when voting took place.
- R8: A `start` pulse clears all three flags and restarts at copy 0, byte 0 in the next cycle, even in the middle of a stream. Each run produces at most one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse that begins a new run |
| in_valid | input | 1 | `in_data` carries a page byte this cycle |
| in_data | input | 8 | Streamed page byte |
| rd_addr | input | 8 | Byte offset to read from the chosen page |
| rd_data | output | 8 | Byte of the chosen page at `rd_addr` |
| done | output | 1 | One-cycle result pulse |
| page_ok | output | 1 | A page passed its checksum |
| page_voted | output | 1 | The passing page was rebuilt by voting |
| page_fail | output | 1 | All copies and the rebuilt page failed |

## Verification
The embedded assertions check the following on every cycle:
- the result flags never contradict each other, and voting is only ever reported as a pass;
- `done` is a single-cycle pulse that always carries exactly one verdict;
- the flags only change on a result or a restart;
- the copy index only advances;
- during voting, every rebuilt byte agrees with a pairwise majority of the stored bytes.

Only the bench scenarios can show the rest:
- that the checksum has the correct seed and byte order, which a page with its two checksum bytes swapped demonstrates;
- that the selected copy is the first good one and that later traffic is ignored;
- that a vote recovers three copies damaged at different places but fails when two copies share the same damaged bit.

// File: rtl/ppv_pkg.sv
package ppv_pkg;

    localparam int          BYTE_W   = 8;
    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h8005;
    localparam logic [15:0] CRC_SEED = 16'h4F4E;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STREAM = 2'd1,
        PH_VOTE   = 2'd2,
        PH_DONE   = 2'd3
    } phase_e;

endpackage

// File: rtl/ppv_crc_step.sv
module ppv_crc_step
    import ppv_pkg::*;
(
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    // One byte of CRC-16, MSB first: byte folded into the upper half,
    // then eight shift/conditional-xor steps.
    always_comb begin
        logic [CRC_W-1:0] acc;
        acc = crc_in ^ {data_in, {(CRC_W-BYTE_W){1'b0}}};
        for (int b = 0; b < BYTE_W; b++) begin
            acc = acc[CRC_W-1] ? ((acc << 1) ^ CRC_POLY) : (acc << 1);
        end
        crc_out = acc;
    end

endmodule

// File: rtl/ppv_vote.sv
module ppv_vote
    import ppv_pkg::*;
#(
    parameter int COPIES = 3
) (
    input  logic [COPIES-1:0][BYTE_W-1:0] copies_in,
    output logic [BYTE_W-1:0]             voted_out
);

    localparam int CNT_W = $clog2(COPIES + 1);

    // Per bit position: population count across copies, strict majority.
    for (genvar bit_i = 0; bit_i < BYTE_W; bit_i++) begin : g_bit
        logic [CNT_W-1:0] ones;
        always_comb begin
            ones = '0;
            for (int c = 0; c < COPIES; c++) begin
                ones = ones + CNT_W'(copies_in[c][bit_i]);
            end
        end
        assign voted_out[bit_i] = (ones > CNT_W'(COPIES / 2));
    end

endmodule

// File: rtl/ppv_store.sv
module ppv_store
    import ppv_pkg::*;
#(
    parameter int SLOTS      = 4,
    parameter int PAGE_BYTES = 256
) (
    input  logic                             clk,
    input  logic                             we,
    input  logic [$clog2(SLOTS)-1:0]         wslot,
    input  logic [$clog2(PAGE_BYTES)-1:0]    waddr,
    input  logic [BYTE_W-1:0]                wdata,
    input  logic [$clog2(PAGE_BYTES)-1:0]    raddr,
    output logic [SLOTS-1:0][BYTE_W-1:0]     rdata
);

    logic [BYTE_W-1:0] mem [SLOTS][PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wslot][waddr] <= wdata;
        end
    end

    // Every slot is read at the same offset so the voter sees all copies.
    for (genvar s = 0; s < SLOTS; s++) begin : g_rd
        assign rdata[s] = mem[s][raddr];
    end

endmodule

// File: rtl/ppv_top.sv
module ppv_top
    import ppv_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int COPIES     = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          in_valid,
    input  logic [BYTE_W-1:0]             in_data,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_addr,
    output logic [BYTE_W-1:0]             rd_data,
    output logic                          done,
    output logic                          page_ok,
    output logic                          page_voted,
    output logic                          page_fail
);

    localparam int AW        = $clog2(PAGE_BYTES);
    localparam int SLOTS     = COPIES + 1;
    localparam int CW        = $clog2(SLOTS);
    localparam int VOTE_SLOT = COPIES;
    localparam logic [AW-1:0] LAST_BYTE = AW'(PAGE_BYTES - 1);
    localparam logic [AW-1:0] CRC_LO_AT = AW'(PAGE_BYTES - 2);
    localparam logic [CW-1:0] LAST_COPY = CW'(COPIES - 1);

    typedef struct packed {
        phase_e              phase;
        logic [CW-1:0]       copy_idx;
        logic [AW-1:0]       byte_idx;
        logic [CRC_W-1:0]    crc;
        logic [BYTE_W-1:0]   crc_lo;
        logic [CW-1:0]       sel;
        logic                done;
        logic                ok;
        logic                voted;
        logic                fail;
    } state_t;

    state_t q, d;

    logic                         step_en;
    logic [BYTE_W-1:0]            feed_byte;
    logic [BYTE_W-1:0]            maj_byte;
    logic [CRC_W-1:0]             crc_next;
    logic                         crc_match;
    logic                         mem_we;
    logic [CW-1:0]                mem_slot;
    logic [AW-1:0]                raddr;
    logic [SLOTS-1:0][BYTE_W-1:0] slot_rd;

    assign step_en   = ((q.phase == PH_STREAM) && in_valid) || (q.phase == PH_VOTE);
    assign feed_byte = (q.phase == PH_VOTE) ? maj_byte : in_data;
    assign crc_match = ({feed_byte, q.crc_lo} == q.crc);
    assign raddr     = (q.phase == PH_VOTE) ? q.byte_idx : rd_addr;

    ppv_store #(
        .SLOTS      (SLOTS),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .wslot (mem_slot),
        .waddr (q.byte_idx),
        .wdata (feed_byte),
        .raddr (raddr),
        .rdata (slot_rd)
    );

    ppv_vote #(
        .COPIES (COPIES)
    ) u_vote (
        .copies_in (slot_rd[COPIES-1:0]),
        .voted_out (maj_byte)
    );

    ppv_crc_step u_crc (
        .crc_in  (q.crc),
        .data_in (feed_byte),
        .crc_out (crc_next)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        mem_we   = 1'b0;
        mem_slot = (q.phase == PH_VOTE) ? CW'(VOTE_SLOT) : q.copy_idx;
        if (start) begin
            d.phase    = PH_STREAM;
            d.copy_idx = '0;
            d.byte_idx = '0;
            d.crc      = CRC_SEED;
            d.crc_lo   = '0;
            d.sel      = '0;
            d.ok       = 1'b0;
            d.voted    = 1'b0;
            d.fail     = 1'b0;
        end else if (step_en) begin
            mem_we = 1'b1;
            if (q.byte_idx < CRC_LO_AT) begin
                d.crc = crc_next;
            end
            if (q.byte_idx == CRC_LO_AT) begin
                d.crc_lo = feed_byte;
            end
            if (q.byte_idx == LAST_BYTE) begin
                d.byte_idx = '0;
                d.crc      = CRC_SEED;
                if (crc_match) begin
                    d.done  = 1'b1;
                    d.ok    = 1'b1;
                    d.voted = (q.phase == PH_VOTE);
                    d.sel   = mem_slot;
                    d.phase = PH_DONE;
                end else if (q.phase == PH_VOTE) begin
                    d.done  = 1'b1;
                    d.fail  = 1'b1;
                    d.sel   = CW'(VOTE_SLOT);
                    d.phase = PH_DONE;
                end else if (q.copy_idx == LAST_COPY) begin
                    d.phase = PH_VOTE;
                end else begin
                    d.copy_idx = q.copy_idx + CW'(1);
                end
            end else begin
                d.byte_idx = q.byte_idx + AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data    = slot_rd[q.sel];
    assign done       = q.done;
    assign page_ok    = q.ok;
    assign page_voted = q.voted;
    assign page_fail  = q.fail;

    // Verdict flags never contradict each other.
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(page_ok && page_fail));

    assert_voted_is_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        page_voted |-> page_ok);

    assert_done_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (page_ok ^ page_fail));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!page_ok && !page_fail && !page_voted && !done));

    // Flags move only with a verdict or a restart.
    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ({page_ok, page_fail} != $past({page_ok, page_fail})) |-> (done || $past(start)));

    assert_copy_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.copy_idx != $past(q.copy_idx)) |->
            ($past(start) || (q.copy_idx == $past(q.copy_idx) + CW'(1))));

    assert_copy_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.copy_idx <= LAST_COPY);

    if (COPIES == 3) begin : g_maj_chk
        assert_majority_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (q.phase == PH_VOTE) |->
                (maj_byte == ((slot_rd[0] & slot_rd[1]) | (slot_rd[1] & slot_rd[2]) |
                              (slot_rd[0] & slot_rd[2]))));
    end

endmodule

// File: tb/ppv_top_bench.sv
module ppv_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PAGE       = 256;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       done, page_ok, page_voted, page_fail;

    ppv_top u_ppv_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .done       (done),
        .page_ok    (page_ok),
        .page_voted (page_voted),
        .page_fail  (page_fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [2:0] flags;   // {ok, voted, fail}
        string      tag;
    } exp_t;

    exp_t       sbq[$];
    int         n_tests = 0;
    int         n_fail  = 0;
    int         n_done  = 0;
    int         cycles  = 0;
    logic [7:0] ref_pg [PAGE];
    logic [7:0] cp     [3][PAGE];
    logic [7:0] exp_rd [PAGE];

    task automatic check(input logic cond, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each result pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (sbq.size() == 0) begin
                check(1'b0, "R8 unexpected done", {page_ok, page_voted, page_fail}, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check({page_ok, page_voted, page_fail} == e.flags, e.tag,
                      {page_ok, page_voted, page_fail}, e.flags);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            check(1'b0, "watchdog expired", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] bench_crc();
        logic [15:0] c;
        c = 16'h4F4E;
        for (int i = 0; i < PAGE - 2; i++) begin
            c = c ^ {ref_pg[i], 8'h00};
            for (int b = 0; b < 8; b++) begin
                c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
            end
        end
        return c;
    endfunction

    task automatic build_good(input int seed);
        logic [15:0] c;
        for (int i = 0; i < PAGE - 2; i++) begin
            ref_pg[i] = 8'((i * 37) ^ (seed * 101) ^ ((i >> 3) * seed));
        end
        c = bench_crc();
        while (c[7:0] == c[15:8]) begin
            ref_pg[0] = ref_pg[0] ^ 8'h01;
            c = bench_crc();
        end
        ref_pg[PAGE-2] = c[7:0];
        ref_pg[PAGE-1] = c[15:8];
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < PAGE; i++) cp[k][i] = ref_pg[i];
        end
        for (int i = 0; i < PAGE; i++) exp_rd[i] = ref_pg[i];
    endtask

    task automatic push_exp(input logic [2:0] f, input string tag);
        exp_t e;
        e.flags = f;
        e.tag   = tag;
        sbq.push_back(e);
    endtask

    task automatic send_copy(input int k);
        for (int i = 0; i < PAGE; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = cp[k][i];
        end
    endtask

    task automatic bus_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        in_valid = 1'b0;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_done(input int target);
        while (n_done < target) @(negedge clk);
    endtask

    task automatic check_page(input string tag);
        int bad;
        logic [7:0] a_v, e_v;
        bad = 0; a_v = 0; e_v = 0;
        for (int a = 0; a < PAGE; a++) begin
            @(negedge clk);
            rd_addr = 8'(a);
            #1;
            if (rd_data !== exp_rd[a] && bad == 0) begin
                a_v = rd_data;
                e_v = exp_rd[a];
            end
            if (rd_data !== exp_rd[a]) bad++;
        end
        check(bad == 0, tag, a_v, e_v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        check({done, page_ok, page_voted, page_fail} == 4'b0, "R8 reset flags",
              {done, page_ok, page_voted, page_fail}, 0);

        // R4: bytes before any start are ignored
        build_good(1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); in_valid = 1'b1; in_data = cp[0][i];
        end
        bus_idle();
        repeat (3) @(negedge clk);
        check(n_done == 0 && !page_ok, "R4 pre-start ignored", n_done, 0);

        // R2: copy 0 good, done one cycle after byte 255
        pulse_start();
        check({page_ok, page_fail} == 2'b00, "R8 flags cleared", {page_ok, page_fail}, 0);
        push_exp(3'b100, "R2 copy0 pass");
        send_copy(0);
        @(negedge clk);
        check(done == 1'b1, "R2 done latency", done, 1);
        in_valid = 1'b0;
        // R4: trailing copies are ignored
        cp[1][5] = cp[1][5] ^ 8'hFF;
        cp[2][7] = cp[2][7] ^ 8'h10;
        send_copy(1);
        send_copy(2);
        bus_idle();
        repeat (4) @(negedge clk);
        check(n_done == 1 && page_ok && !page_voted, "R4 trailing ignored", n_done, 1);
        check_page("R7 readback copy0");

        // R1: checksum bytes swapped on copy 0 -> copy 1 chosen
        build_good(2);
        cp[0][PAGE-2] = ref_pg[PAGE-1];
        cp[0][PAGE-1] = ref_pg[PAGE-2];
        pulse_start();
        push_exp(3'b100, "R1 swapped crc rejects copy0");
        send_copy(0);
        send_copy(1);
        bus_idle();
        wait_done(2);
        check_page("R1 readback copy1 byte order");

        // R3: copies 0 and 1 corrupted, copy 2 good
        build_good(3);
        cp[0][40] = cp[0][40] ^ 8'h04;
        cp[1][254] = cp[1][254] ^ 8'h80;
        pulse_start();
        push_exp(3'b100, "R3 copy2 pass");
        send_copy(0);
        send_copy(1);
        send_copy(2);
        bus_idle();
        wait_done(3);
        check_page("R3 readback copy2");

        // R5/R6: distinct damage in every copy -> vote recovers
        build_good(4);
        cp[0][10] = cp[0][10] ^ 8'h01;
        cp[1][20] = cp[1][20] ^ 8'h08;
        cp[2][255] = cp[2][255] ^ 8'h80;
        pulse_start();
        push_exp(3'b110, "R6 vote recovered");
        send_copy(0);
        send_copy(1);
        send_copy(2);
        bus_idle();
        wait_done(4);
        check_page("R5 voted page equals original");

        // R5/R6: two copies share a flipped bit -> vote fails
        build_good(5);
        cp[0][10] = cp[0][10] ^ 8'h01;
        cp[1][10] = cp[1][10] ^ 8'h01;
        cp[2][50] = cp[2][50] ^ 8'h20;
        exp_rd[10] = exp_rd[10] ^ 8'h01;
        pulse_start();
        push_exp(3'b001, "R6 vote fails");
        send_copy(0);
        send_copy(1);
        send_copy(2);
        bus_idle();
        wait_done(5);
        check(!page_ok && page_fail, "R6 fail level held", {page_ok, page_fail}, 1);
        check_page("R5 majority keeps shared flip");

        // R8: start clears a failure and aborts a partial stream
        pulse_start();
        check({page_ok, page_voted, page_fail} == 3'b000, "R8 fail cleared",
              {page_ok, page_voted, page_fail}, 0);
        build_good(6);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); in_valid = 1'b1; in_data = 8'(i * 3);
        end
        pulse_start();
        push_exp(3'b100, "R8 restart at copy0");
        send_copy(0);
        bus_idle();
        wait_done(6);
        check_page("R8 readback after restart");

        repeat (5) @(negedge clk);
        check(sbq.size() == 0 && n_done == 6, "R8 one done per run", n_done, 6);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule